// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Sequencer

This block decides, frame by frame, where an LCD controller's fetch engine should read. Two frame-buffer regions are available, each given as a top and a bottom byte address. When the controller is switched on, the sequencer checks that the addresses of the regions in use are valid and picks buffer 0. On every frame request it works out how many bytes the frame needs. It then issues a start command with the stream address, byte count, palette length and displayed line window. If the frame would overrun its region, it instead reports a sync error and asks for the controller to be switched off.

Palette handling follows the palette load mode. In modes 0 and 3 a 512-byte palette sits at the top of the buffer, and the pixel data is shifted past it by a depth-dependent offset. Mode 2 fetches pixels only. Mode 1 loads the palette and shows nothing, so frame requests are dropped. Each frame start sets a DMA condition bit matching the buffer it used, and can raise the DMA interrupt. In dual mode the buffer index alternates after every frame.

All outputs are registered. Every pulse and every start field appears in the cycle after the clock edge that sampled the causing input.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, and in every cycle after one where `enable` is low, `buf_valid` is 0. The first clock edge with `enable` high selects buffer 0 (`buf_valid`=1, `buf_idx`=0).
- R2: On that first enabled edge the sequencer checks `addr_ok`: bit 0 is buffer 0 top, bit 1 is buffer 0 bottom, bit 2 is buffer 1 top and bit 3 is buffer 1 bottom. Bits 2 and 3 are checked only when `dual` is 1. On a failure, `dma_cond[2]` pulses, `dma_irq` pulses if `dma_ie[1]` is set, and no frame starts until `enable` has been low.
- R3: `frame_req` is ignored (no pulse of any kind follows) when `plm` is 1, when `depth` is 5, 6 or 7, while a frame is in flight, or after a halt.
- R4: `pal_len` is 512 when `plm` is not 2 and 0 when it is 2. The pixel offset is 0 when `plm` is 2. Otherwise it is 512 for depth code 2, 32 for depth codes 0 and 1, and 0 for codes 3 and 4.
- R5: The current region size is bottom minus top, taken as a signed value. A frame whose offset plus total bytes exceeds size + 2 produces `sync_err` and `off_req` pulses instead of a start. No further frame starts until `enable` has been low.
- R6: A frame that fits pulses `start_vld`. Depth codes 0..4 mean 2, 4, 8, 12 and 16 bits per pixel. `start_bytes` = floor(lines·width·bits/8) and `start_addr` = top + offset + floor(first·width·bits/8). `pal_addr` is the buffer top. In the same cycle, `dma_cond` bit `buf_idx` (0 or 1) pulses, and `dma_irq` pulses if `dma_ie[0]` is set.
- R7: After each frame start the buffer index flips when `dual` is 1 and holds when it is 0.
- R8: Width and height are `width_m1`+1 and `height_m1`+1. With `sub_en` clear, first = 0 and lines = height. With `sub_en` and `sub_first` set, first = `sub_val` and lines = height − `sub_val` (0 if `sub_val` ≥ height). With only `sub_en` set, first = 0 and lines = min(`sub_val`, height).
- R9: While a frame is in flight, `xfer_done` pulses `frame_done` and ends the frame. `pal_ack` pulses `palette_done` only when that frame's `pal_len` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller on |
| dual | input | 1 | Alternate between the two buffers |
| plm | input | 2 | Palette load mode |
| depth | input | 3 | Pixel depth code |
| width_m1 | input | LW | Panel width minus one |
| height_m1 | input | LW | Panel height minus one |
| sub_en | input | 1 | Sub-panel window active |
| sub_first | input | 1 | Sub-panel value is first line (else line count) |
| sub_val | input | LW | Sub-panel line value |
| top0 | input | AW | Buffer 0 top address |
| bot0 | input | AW | Buffer 0 bottom address |
| top1 | input | AW | Buffer 1 top address |
| bot1 | input | AW | Buffer 1 bottom address |
| addr_ok | input | 4 | Validity of top0, bot0, top1, bot1 |
| dma_ie | input | 2 | DMA interrupt enables (0 frame start, 1 address fault) |
| frame_req | input | 1 | Request to start a frame |
| pal_ack | input | 1 | Fetch engine finished the palette |
| xfer_done | input | 1 | Fetch engine accepted the last frame byte |
| buf_valid | output | 1 | A buffer is selected |
| buf_idx | output | 1 | Current buffer index |
| start_vld | output | 1 | Frame start pulse |
| start_addr | output | AW | Pixel stream start address |
| start_bytes | output | 2·LW+4 | Pixel stream byte count |
| pal_addr | output | AW | Palette address |
| pal_len | output | 10 | Palette length in bytes |
| first_line | output | LW | First displayed line |
| line_cnt | output | LW+1 | Displayed line count |
| frame_done | output | 1 | Frame finished pulse |
| palette_done | output | 1 | Palette loaded pulse |
| sync_err | output | 1 | Frame overruns its region |
| off_req | output | 1 | Request to clear the controller enable |
| dma_cond | output | 3 | DMA condition set pulses |
| dma_irq | output | 1 | DMA interrupt pulse |

## Verification
The assertions check the invariants that hold in every cycle. A sync error always comes with an off request. A start sets exactly one of the two buffer condition bits. Start, sync error and frame-done pulses are mutually exclusive. No start follows an off request, and disabling clears the buffer selection. The arithmetic can only be shown by the bench's scenarios, which compare against a behavioural model: the exact address and byte count per depth, the size+2 boundary on either side, sub-panel windows, dual-mode alternation across frames, and requests dropped in the palette-only mode or while busy.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_LINE_W = 10;
    localparam int PAL_W      = 10;
    localparam logic [PAL_W-1:0] PAL_BYTES = 10'd512;

    typedef enum logic [1:0] {
        PLM_BOTH     = 2'd0,
        PLM_PAL_ONLY = 2'd1,
        PLM_PIX_ONLY = 2'd2,
        PLM_BOTH_ALT = 2'd3
    } pal_mode_e;

    typedef enum logic [2:0] {
        PX2  = 3'd0,
        PX4  = 3'd1,
        PX8  = 3'd2,
        PX12 = 3'd3,
        PX16 = 3'd4
    } px_depth_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_READY,
        ST_BUSY,
        ST_HALT
    } seq_state_e;

    // bits per pixel for a depth code, 0 when unsupported
    function automatic logic [4:0] depth_bits(input logic [2:0] code);
        case (code)
            PX2:     return 5'd2;
            PX4:     return 5'd4;
            PX8:     return 5'd8;
            PX12:    return 5'd12;
            PX16:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    // byte offset of pixel data past the palette block
    function automatic logic [PAL_W-1:0] pix_offset(input logic [1:0] mode,
                                                     input logic [2:0] code);
        if (mode == PLM_PIX_ONLY) return '0;
        case (code)
            PX8:      return 10'd512;
            PX2, PX4: return 10'd32;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/lcdf_geom.sv
module lcdf_geom
    import lcdf_pkg::*;
#(
    parameter int AW = DEF_ADDR_W,
    parameter int LW = DEF_LINE_W
) (
    input  logic [1:0]      plm,
    input  logic [2:0]      depth,
    input  logic [LW-1:0]   width_m1,
    input  logic [LW-1:0]   height_m1,
    input  logic            sub_en,
    input  logic            sub_first,
    input  logic [LW-1:0]   sub_val,
    input  logic [AW-1:0]   top,
    input  logic [AW-1:0]   bot,
    output logic            depth_ok,
    output logic            fits,
    output logic [AW-1:0]   start_addr,
    output logic [2*LW+3:0] byte_cnt,
    output logic [LW-1:0]   first_line,
    output logic [LW:0]     line_cnt,
    output logic [PAL_W-1:0] pal_len
);
    localparam int PW = 2*LW + 7;

    logic [LW:0]        wid, hgt;
    logic [4:0]         bits;
    logic [PAL_W-1:0]   offset;
    logic [PW-1:0]      tot_bits, row_bits, cnt_bits;
    logic [AW+1:0]      need_u;
    logic signed [AW+1:0] span;

    always_comb begin
        wid    = {1'b0, width_m1} + (LW+1)'(1);
        hgt    = {1'b0, height_m1} + (LW+1)'(1);
        bits   = depth_bits(depth);
        offset = pix_offset(plm, depth);
        depth_ok = (bits != 5'd0);
        pal_len  = (plm == PLM_PIX_ONLY) ? '0 : PAL_BYTES;

        tot_bits = PW'(wid) * PW'(hgt) * PW'(bits);
        need_u   = (AW+2)'(tot_bits >> 3) + (AW+2)'(offset);
        span     = $signed({2'b00, bot}) - $signed({2'b00, top});
        fits     = ($signed(need_u) <= (span + 2));

        if (sub_en && sub_first) begin
            first_line = sub_val;
            line_cnt   = ({1'b0, sub_val} < hgt) ? (hgt - {1'b0, sub_val}) : '0;
        end else if (sub_en) begin
            first_line = '0;
            line_cnt   = ({1'b0, sub_val} < hgt) ? {1'b0, sub_val} : hgt;
        end else begin
            first_line = '0;
            line_cnt   = hgt;
        end

        row_bits   = PW'(first_line) * PW'(wid) * PW'(bits);
        cnt_bits   = PW'(line_cnt) * PW'(wid) * PW'(bits);
        start_addr = top + AW'(offset) + AW'(row_bits >> 3);
        byte_cnt   = (2*LW+4)'(cnt_bits >> 3);
    end
endmodule

// File: rtl/lcdf_bufsel.sv
module lcdf_bufsel (
    input  logic clk,
    input  logic rst,
    input  logic disarm,
    input  logic arm,
    input  logic advance,
    output logic buf_valid,
    output logic buf_idx
);
    always_ff @(posedge clk) begin
        if (rst || disarm) begin
            buf_valid <= 1'b0;
            buf_idx   <= 1'b0;
        end else if (arm) begin
            buf_valid <= 1'b1;
            buf_idx   <= 1'b0;
        end else if (advance) begin
            buf_idx   <= ~buf_idx;
        end
    end
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcdf_pkg::*;
#(
    parameter int AW = DEF_ADDR_W,
    parameter int LW = DEF_LINE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            dual,
    input  logic [1:0]      plm,
    input  logic [2:0]      depth,
    input  logic [LW-1:0]   width_m1,
    input  logic [LW-1:0]   height_m1,
    input  logic            sub_en,
    input  logic            sub_first,
    input  logic [LW-1:0]   sub_val,
    input  logic [AW-1:0]   top0,
    input  logic [AW-1:0]   bot0,
    input  logic [AW-1:0]   top1,
    input  logic [AW-1:0]   bot1,
    input  logic [3:0]      addr_ok,
    input  logic [1:0]      dma_ie,
    input  logic            frame_req,
    input  logic            pal_ack,
    input  logic            xfer_done,
    output logic            buf_valid,
    output logic            buf_idx,
    output logic            start_vld,
    output logic [AW-1:0]   start_addr,
    output logic [2*LW+3:0] start_bytes,
    output logic [AW-1:0]   pal_addr,
    output logic [9:0]      pal_len,
    output logic [LW-1:0]   first_line,
    output logic [LW:0]     line_cnt,
    output logic            frame_done,
    output logic            palette_done,
    output logic            sync_err,
    output logic            off_req,
    output logic [2:0]      dma_cond,
    output logic            dma_irq
);
    localparam int BW = 2*LW + 4;

    seq_state_e      state;
    logic [AW-1:0]   cur_top, cur_bot, g_addr;
    logic [BW-1:0]   g_bytes;
    logic [LW-1:0]   g_first;
    logic [LW:0]     g_lines;
    logic [PAL_W-1:0] g_pal;
    logic            g_depth_ok, g_fits;
    logic            regions_ok, frame_go, launch;

    assign cur_top = buf_idx ? top1 : top0;
    assign cur_bot = buf_idx ? bot1 : bot0;

    lcdf_geom #(.AW(AW), .LW(LW)) u_geom (
        .plm(plm), .depth(depth), .width_m1(width_m1), .height_m1(height_m1),
        .sub_en(sub_en), .sub_first(sub_first), .sub_val(sub_val),
        .top(cur_top), .bot(cur_bot),
        .depth_ok(g_depth_ok), .fits(g_fits), .start_addr(g_addr),
        .byte_cnt(g_bytes), .first_line(g_first), .line_cnt(g_lines),
        .pal_len(g_pal)
    );

    always_comb begin
        regions_ok = addr_ok[0] && addr_ok[1] && (!dual || (addr_ok[2] && addr_ok[3]));
        frame_go   = enable && (state == ST_READY) && frame_req
                     && (plm != PLM_PAL_ONLY) && g_depth_ok;
        launch     = frame_go && g_fits;
    end

    lcdf_bufsel u_buf (
        .clk(clk), .rst(rst),
        .disarm(!enable),
        .arm(enable && (state == ST_OFF)),
        .advance(launch && dual),
        .buf_valid(buf_valid), .buf_idx(buf_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_OFF;
            start_vld    <= 1'b0;
            start_addr   <= '0;
            start_bytes  <= '0;
            pal_addr     <= '0;
            pal_len      <= '0;
            first_line   <= '0;
            line_cnt     <= '0;
            frame_done   <= 1'b0;
            palette_done <= 1'b0;
            sync_err     <= 1'b0;
            off_req      <= 1'b0;
            dma_cond     <= '0;
            dma_irq      <= 1'b0;
        end else begin
            start_vld    <= 1'b0;
            frame_done   <= 1'b0;
            palette_done <= 1'b0;
            sync_err     <= 1'b0;
            off_req      <= 1'b0;
            dma_cond     <= '0;
            dma_irq      <= 1'b0;
            if (!enable) begin
                state <= ST_OFF;
            end else begin
                case (state)
                    ST_OFF: begin
                        if (regions_ok) begin
                            state <= ST_READY;
                        end else begin
                            dma_cond[2] <= 1'b1;
                            dma_irq     <= dma_ie[1];
                            state       <= ST_HALT;
                        end
                    end
                    ST_READY: begin
                        if (launch) begin
                            start_vld   <= 1'b1;
                            start_addr  <= g_addr;
                            start_bytes <= g_bytes;
                            pal_addr    <= cur_top;
                            pal_len     <= g_pal;
                            first_line  <= g_first;
                            line_cnt    <= g_lines;
                            dma_cond[buf_idx] <= 1'b1;
                            dma_irq     <= dma_ie[0];
                            state       <= ST_BUSY;
                        end else if (frame_go) begin
                            sync_err <= 1'b1;
                            off_req  <= 1'b1;
                            state    <= ST_HALT;
                        end
                    end
                    ST_BUSY: begin
                        if (pal_ack && (pal_len != '0)) palette_done <= 1'b1;
                        if (xfer_done) begin
                            frame_done <= 1'b1;
                            state      <= ST_READY;
                        end
                    end
                    default: state <= ST_HALT;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       buf_valid,
    input logic       start_vld,
    input logic       frame_done,
    input logic       sync_err,
    input logic       off_req,
    input logic [2:0] dma_cond
);
    // R5
    sync_off_pair_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> off_req);

    // R6
    start_cond_chk: assert property (@(posedge clk) disable iff (rst)
        start_vld |-> ($countones(dma_cond[1:0]) == 1) && !dma_cond[2]);

    // R5
    no_start_after_off_chk: assert property (@(posedge clk) disable iff (rst)
        off_req |=> !start_vld);

    // R1
    disable_clears_buf_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !buf_valid);

    // R9
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_vld, sync_err, frame_done}));

    // R6
    start_needs_buf_chk: assert property (@(posedge clk) disable iff (rst)
        start_vld |-> buf_valid);
endmodule

bind lcd_frame_seq lcd_frame_seq_chk u_chk (
    .clk(clk), .rst(rst), .enable(enable), .buf_valid(buf_valid),
    .start_vld(start_vld), .frame_done(frame_done), .sync_err(sync_err),
    .off_req(off_req), .dma_cond(dma_cond)
);

// File: tb/lcd_frame_seq_test.sv
module lcd_frame_seq_test;
    localparam int AW = 32;
    localparam int LW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 0, dual = 0, sub_en = 0, sub_first = 0;
    logic [1:0] plm = 0, dma_ie = 0;
    logic [2:0] depth = 0;
    logic [LW-1:0] width_m1 = 0, height_m1 = 0, sub_val = 0;
    logic [AW-1:0] top0 = 0, bot0 = 0, top1 = 0, bot1 = 0;
    logic [3:0] addr_ok = 4'hf;
    logic frame_req = 0, pal_ack = 0, xfer_done = 0;

    logic buf_valid, buf_idx, start_vld, frame_done, palette_done, sync_err, off_req, dma_irq;
    logic [AW-1:0] start_addr, pal_addr;
    logic [2*LW+3:0] start_bytes;
    logic [9:0] pal_len;
    logic [LW-1:0] first_line;
    logic [LW:0] line_cnt;
    logic [2:0] dma_cond;

    always #4 clk = ~clk;

    lcd_frame_seq #(.AW(AW), .LW(LW)) uut (.*);

    int n_vec = 0, n_bad = 0, cycles = 0;
    bit started = 0;

    // behavioural reference: mode 0 off, 1 ready, 2 busy, 3 halted
    int m_mode = 0, m_buf = -1;
    bit e_start, e_fdone, e_pdone, e_sync, e_off, e_irq;
    int e_cond;
    longint e_addr, e_bytes, e_paddr, e_plen, e_first, e_lines;

    function automatic int bpp_of(int c);
        case (c) 0: return 2; 1: return 4; 2: return 8; 3: return 12; 4: return 16; default: return 0; endcase
    endfunction

    always @(posedge clk) begin
        longint w, h, b, off, sz, need, top, bot, fl, ln;
        started = 1;
        e_start = 0; e_fdone = 0; e_pdone = 0; e_sync = 0; e_off = 0; e_irq = 0; e_cond = 0;
        if (rst) begin
            m_mode = 0; m_buf = -1;
            e_addr = 0; e_bytes = 0; e_paddr = 0; e_plen = 0; e_first = 0; e_lines = 0;
        end else if (!enable) begin
            m_mode = 0; m_buf = -1;
        end else if (m_mode == 0) begin
            m_buf = 0;
            if (addr_ok[0] && addr_ok[1] && (!dual || (addr_ok[2] && addr_ok[3]))) m_mode = 1;
            else begin e_cond = 4; e_irq = dma_ie[1]; m_mode = 3; end
        end else if (m_mode == 1) begin
            b = bpp_of(int'(depth));
            if (frame_req && plm != 1 && b != 0) begin
                w = longint'(width_m1) + 1; h = longint'(height_m1) + 1;
                top = (m_buf == 1) ? longint'(top1) : longint'(top0);
                bot = (m_buf == 1) ? longint'(bot1) : longint'(bot0);
                if (plm == 2) off = 0; else if (b == 8) off = 512; else if (b <= 4) off = 32; else off = 0;
                sz = bot - top;
                need = off + (w * h * b) / 8;
                if (need > sz + 2) begin
                    e_sync = 1; e_off = 1; m_mode = 3;
                end else begin
                    fl = 0; ln = h;
                    if (sub_en && sub_first) begin fl = sub_val; ln = (sub_val < h) ? h - sub_val : 0; end
                    else if (sub_en) ln = (sub_val < h) ? sub_val : h;
                    e_start = 1;
                    e_addr = (top + off + (fl * w * b) / 8) & 64'hffff_ffff;
                    e_bytes = (ln * w * b) / 8;
                    e_paddr = top; e_plen = (plm == 2) ? 0 : 512;
                    e_first = fl; e_lines = ln;
                    e_cond = 1 << m_buf; e_irq = dma_ie[0];
                    if (dual) m_buf = 1 - m_buf;
                    m_mode = 2;
                end
            end
        end else if (m_mode == 2) begin
            if (pal_ack && e_plen != 0) e_pdone = 1;
            if (xfer_done) begin e_fdone = 1; m_mode = 1; end
        end
    end

    task automatic cmp(string req, string name, longint act, longint exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            cycles++;
            n_vec++;
            cmp("R1", "buf_valid", buf_valid, m_buf >= 0);
            if (m_buf >= 0) cmp("R7", "buf_idx", buf_idx, m_buf);
            cmp("R3/R6", "start_vld", start_vld, e_start);
            cmp("R5", "sync_err", sync_err, e_sync);
            cmp("R5", "off_req", off_req, e_off);
            cmp("R2/R6", "dma_cond", dma_cond, e_cond);
            cmp("R2/R6", "dma_irq", dma_irq, e_irq);
            cmp("R9", "frame_done", frame_done, e_fdone);
            cmp("R9", "palette_done", palette_done, e_pdone);
            if (e_start) begin
                cmp("R6", "start_addr", start_addr, e_addr);
                cmp("R6", "start_bytes", start_bytes, e_bytes);
                cmp("R6", "pal_addr", pal_addr, e_paddr);
                cmp("R4", "pal_len", pal_len, e_plen);
                cmp("R8", "first_line", first_line, e_first);
                cmp("R8", "line_cnt", line_cnt, e_lines);
            end
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) frame_req = 1;
        @(negedge clk) frame_req = 0;
    endtask

    task automatic finish_frame();
        @(negedge clk) pal_ack = 1;
        @(negedge clk) pal_ack = 0; xfer_done = 1;
        @(negedge clk) xfer_done = 0;
    endtask

    task automatic reenable();
        @(negedge clk) enable = 0;
        @(negedge clk) enable = 1;
        idle(2);
    endtask

    initial begin
        idle(4);
        @(negedge clk) rst = 0;
        idle(3); // R1 reset state: no buffer selected

        // R1 R6 R4 R9: 8 bpp with palette, exact fit at size
        width_m1 = 15; height_m1 = 7; depth = 2; plm = 0; dma_ie = 2'b01;
        top0 = 32'h1000; bot0 = 32'h1280; top1 = 32'h4000; bot1 = 32'h6000;
        @(negedge clk) enable = 1;
        idle(2);
        pulse_req(); idle(1); pulse_req(); // R3: second request while busy ignored
        finish_frame(); idle(2);

        // R5 boundary: need = size + 2 passes
        bot0 = 32'h127e; pulse_req(); finish_frame();
        // R5 boundary: need = size + 3 fails, halts
        bot0 = 32'h127d; pulse_req(); idle(2); pulse_req(); idle(2);
        bot0 = 32'h2000; reenable();

        // R7 dual alternation, 4 bpp pixel-only, palette_done suppressed (R9)
        dual = 1; plm = 2; depth = 1; dma_ie = 2'b11;
        reenable();
        for (int k = 0; k < 4; k++) begin pulse_req(); finish_frame(); end

        // R2: bad address on buffer 1 top in dual mode
        addr_ok = 4'b1011; reenable(); pulse_req(); idle(2);
        // R2: same fault ignored in single mode
        dual = 0; reenable(); pulse_req(); finish_frame();
        addr_ok = 4'hf;

        // R3: palette-only mode and unsupported depth ignored
        plm = 1; pulse_req(); idle(2);
        plm = 3; depth = 6; pulse_req(); idle(2);

        // R8 sub-panel variants with 16 and 12 bpp and 2 bpp
        depth = 4; plm = 2; sub_en = 1; sub_first = 1; sub_val = 3;
        pulse_req(); finish_frame();
        sub_val = 9; pulse_req(); finish_frame();
        sub_first = 0; sub_val = 5; depth = 3; pulse_req(); finish_frame();
        sub_val = 40; depth = 0; plm = 0; width_m1 = 6; pulse_req(); finish_frame();
        sub_en = 0;

        // R1: disable drops selection, then random traffic
        @(negedge clk) enable = 0; idle(2);
        @(negedge clk) enable = 1;
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            frame_req = ($urandom_range(0, 3) == 0);
            pal_ack   = ($urandom_range(0, 2) == 0);
            xfer_done = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 60) == 0) begin
                enable = ~enable; dual = $urandom_range(0, 1);
                plm = 2'($urandom_range(0, 3)); depth = 3'($urandom_range(0, 5));
                width_m1 = LW'($urandom_range(0, 40)); height_m1 = LW'($urandom_range(0, 30));
                sub_en = $urandom_range(0, 1); sub_first = $urandom_range(0, 1);
                sub_val = LW'($urandom_range(0, 35));
                bot0 = top0 + 32'($urandom_range(0, 3000));
                bot1 = top1 + 32'($urandom_range(0, 3000));
                addr_ok = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'hf;
                dma_ie = 2'($urandom_range(0, 3));
            end
        end
        frame_req = 0; pal_ack = 0; xfer_done = 0;
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule